// File: doc/BRIEF.md
# Endian-Configurable Byte-Addressable Memory Port

The block is a data memory in which every address holds one byte. A single request port moves 8-, 16-, 32- or 64-bit values. A store breaks the value into bytes and places them at consecutive addresses starting at the request address. A load gathers the bytes from consecutive addresses and rebuilds the value.

A mode input chooses the byte order for each request. In little-endian order the least significant byte sits at the lowest address. In big-endian order the most significant byte sits there.

Every multi-byte request must start on an address that is a multiple of its width. A request that breaks this rule changes nothing in memory and returns no data. Instead it raises an error pulse for one cycle. Loads return registered data one clock after the request, with every bit above the access width forced to zero.

Top module: `endian_mem_port`

## Requirements
- R1: Each address stores one byte. Size code 0 moves 8 bits at the request address. It is never misaligned, and the endian mode has no effect on it.
- R2: With bigEndian low, byte k of the value (bits 8k+7..8k) is at address addr+k.
- R3: With bigEndian high, byte k of an N-byte value is at address addr+N-1-k.
- R4: Size codes 1, 2 and 3 move 2, 4 and 8 bytes. Such a request is aligned only when addr is a multiple of that byte count.
- R5: A misaligned request drives misalign high for exactly the next cycle. It writes no byte, does not assert rdValid and leaves rdData unchanged.
- R6: An aligned load drives rdValid high and rdData with the value in the cycle after the strobe. In every other cycle rdValid is low and rdData holds its last value.
- R7: All rdData bits above the access width read as zero.
- R8: When rdEn and wrEn are high together, only the write is performed, and rdValid stays low.
- R9: After reset, rdData, rdValid and misalign are all zero.
- R10: Writing in one byte order and reading the same address range in the other returns the value with its bytes reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Load strobe |
| wrEn | input | 1 | Store strobe |
| addr | input | ADDR_W | Byte address of the lowest byte of the access |
| size | input | 2 | Access width: 0=8, 1=16, 2=32, 3=64 bits |
| bigEndian | input | 1 | 1 selects big-endian byte order |
| wrData | input | 64 | Store value, right-justified |
| rdData | output | 64 | Registered load value, zero-filled |
| rdValid | output | 1 | rdData updated by the load of the previous cycle |
| misalign | output | 1 | Previous request was misaligned |

## Verification
The bench writes a known 32-bit pattern in each byte order and reads it back one byte at a time. A design that swapped or shifted lanes would put a wrong byte at some address. Reading in the opposite order checks the byte reversal. A narrow read that follows a wide one checks that stale upper bits are cleared.

Misaligned stores are followed by reads of the bytes they targeted, so a design that let a bad request write would show corrupted memory. Aligned accesses at the edge of each width, and odd-address byte accesses, catch an alignment mask that is off by one size. Simultaneous strobes confirm that the write lands and that no read result is reported.

// File: rtl/endian_mem_pkg.sv
package endian_mem_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrStb;
    logic       rdStb;
    logic       bigEnd;
    logic [3:0] nBytes;
  } memCmd_t;
endpackage

// File: rtl/endian_mem_ctrl.sv
module endian_mem_ctrl
  import endian_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              bigEndian,
  output memCmd_t           cmd,
  output logic              misalign
);
  accSize_e   sizeE;
  logic [3:0] nBytes;
  logic [3:0] lowMask;
  logic       aligned;
  logic       anyReq;

  always_comb begin
    sizeE   = accSize_e'(size);
    nBytes  = 4'd1 << sizeE;
    lowMask = nBytes - 4'd1;
    aligned = ((addr[2:0] & lowMask[2:0]) == 3'd0);
    anyReq  = rdEn | wrEn;

    cmd.wrStb  = wrEn & aligned;
    cmd.rdStb  = rdEn & ~wrEn & aligned;
    cmd.bigEnd = bigEndian & (sizeE != SZ_BYTE);
    cmd.nBytes = nBytes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) misalign <= 1'b0;
    else       misalign <= anyReq & ~aligned;
  end
endmodule

// File: rtl/endian_mem_datapath.sv
module endian_mem_datapath
  import endian_mem_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  memCmd_t           cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(LANES) + 2;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] laneAddr [LANES];
  logic [7:0]        wrByte   [LANES];
  logic              laneAct  [LANES];
  logic [DATA_W-1:0] gathered;

  // lane i is address offset i; the same mapping gives significance
  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [CW-1:0] mapIdx;
    always_comb begin
      laneAct[i] = (CW'(i) < CW'(cmd.nBytes));
      mapIdx     = cmd.bigEnd ? (CW'(cmd.nBytes) - CW'(1) - CW'(i)) : CW'(i);
      if (!laneAct[i]) mapIdx = CW'(i);
      laneAddr[i] = addr + ADDR_W'(mapIdx);
      wrByte[i]   = wrData[8*mapIdx[CW-2:0] +: 8];
    end
    // read: significance i comes from offset mapIdx
    assign gathered[8*i +: 8] = laneAct[i] ? mem[laneAddr[i]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (cmd.wrStb && laneAct[i]) mem[addr + ADDR_W'(i)] <= wrByte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= cmd.rdStb;
      if (cmd.rdStb) rdData <= gathered;
    end
  end
endmodule

// File: rtl/endian_mem_port.sv
module endian_mem_port
  import endian_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              bigEndian,
  input  logic [63:0]       wrData,
  output logic [63:0]       rdData,
  output logic              rdValid,
  output logic              misalign
);
  memCmd_t cmd;

  endian_mem_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .size(size), .bigEndian(bigEndian), .cmd(cmd), .misalign(misalign)
  );

  endian_mem_datapath #(.ADDR_W(ADDR_W), .DATA_W(64)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/endian_mem_chk.sv
module endian_mem_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic [63:0]       rdData,
  input logic              rdValid,
  input logic              misalign
);
  logic badReq;
  always_comb badReq = (rdEn | wrEn) && ((addr[2:0] & ((3'd1 << size) - 3'd1)) != 3'd0);

  a_r5_misalign_flag: assert property (@(posedge clk) disable iff (!rstN)
    badReq |=> misalign);
  a_r4_aligned_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    !badReq |=> !misalign);
  a_r5_no_valid_on_err: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> !rdValid);
  a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !badReq) |=> rdValid);
  a_r8_no_valid_on_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !rdValid);
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> $stable(rdData));
  a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ((rdData >> (7'd8 << $past(size))) == 64'd0));
endmodule

bind endian_mem_port endian_mem_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
  .size(size), .rdData(rdData), .rdValid(rdValid), .misalign(misalign)
);

// File: tb/sim_endian_mem_port.sv
module sim_endian_mem_port;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdEn = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    size = '0;
  logic          bigEndian = 1'b0;
  logic [63:0]   wrData = '0;
  logic [63:0]   rdData;
  logic          rdValid;
  logic          misalign;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_mem_port #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .size(size), .bigEndian(bigEndian), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .misalign(misalign)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request for one cycle; returns after outputs have settled
  task automatic acc(input logic rd, input logic wr, input logic [AW-1:0] a,
                     input logic [1:0] sz, input logic be, input logic [63:0] d);
    @(negedge clk);
    rdEn = rd; wrEn = wr; addr = a; size = sz; bigEndian = be; wrData = d;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic readChk(input logic [AW-1:0] a, input logic [1:0] sz, input logic be,
                         input logic [63:0] exp, input string tag);
    acc(1'b1, 1'b0, a, sz, be, 64'd0);
    check(rdValid === 1'b1 && rdData === exp, tag, rdData, exp);
  endtask

  task automatic tReset();
    check(rdData === 64'd0 && rdValid === 1'b0 && misalign === 1'b0, "R9 reset",
          {rdData[61:0], rdValid, misalign}, 64'd0);
  endtask

  task automatic tLittle();
    acc(1'b0, 1'b1, 10'h100, 2'd2, 1'b0, 64'h46789654);
    readChk(10'h100, 2'd0, 1'b0, 64'h54, "R2 byte at base");
    readChk(10'h101, 2'd0, 1'b0, 64'h96, "R2 byte base+1");
    readChk(10'h103, 2'd0, 1'b1, 64'h46, "R1 byte read ignores endian");
    readChk(10'h100, 2'd2, 1'b0, 64'h46789654, "R2 word read back");
  endtask

  task automatic tBig();
    acc(1'b0, 1'b1, 10'h200, 2'd2, 1'b1, 64'h46789654);
    readChk(10'h200, 2'd0, 1'b0, 64'h46, "R3 MSB at base");
    readChk(10'h203, 2'd0, 1'b0, 64'h54, "R3 LSB at base+3");
    acc(1'b0, 1'b1, 10'h120, 2'd1, 1'b1, 64'hBEEF);
    readChk(10'h120, 2'd0, 1'b0, 64'hBE, "R3 half MSB at base");
  endtask

  task automatic tCross();
    readChk(10'h100, 2'd2, 1'b1, 64'h54967846, "R10 word reversed");
    acc(1'b0, 1'b1, 10'h108, 2'd3, 1'b0, 64'h0123456789ABCDEF);
    readChk(10'h108, 2'd3, 1'b1, 64'hEFCDAB8967452301, "R10 dword reversed");
    readChk(10'h120, 2'd1, 1'b0, 64'hEFBE, "R10 half reversed");
  endtask

  task automatic tZeroFill();
    readChk(10'h108, 2'd3, 1'b0, 64'h0123456789ABCDEF, "R7 full width");
    readChk(10'h10C, 2'd0, 1'b0, 64'h67, "R7 byte zero-filled");
    readChk(10'h10C, 2'd1, 1'b0, 64'h4567, "R7 half zero-filled");
  endtask

  task automatic tMisalign();
    acc(1'b0, 1'b1, 10'h102, 2'd2, 1'b0, 64'hFFFFFFFF);
    check(misalign === 1'b1, "R5 misalign flag", {63'd0, misalign}, 64'd1);
    @(negedge clk);
    check(misalign === 1'b0, "R5 one cycle only", {63'd0, misalign}, 64'd0);
    readChk(10'h100, 2'd2, 1'b0, 64'h46789654, "R5 no write on misalign");
    readChk(10'h104, 2'd0, 1'b0, 64'h00 | 64'h00, "R5 neighbour untouched") ;
    acc(1'b1, 1'b0, 10'h101, 2'd1, 1'b0, 64'd0);
    check(misalign === 1'b1 && rdValid === 1'b0 && rdData === 64'h0,
          "R5 misaligned read", rdData, 64'h0);
    acc(1'b1, 1'b0, 10'h104, 2'd3, 1'b0, 64'd0);
    check(misalign === 1'b1, "R4 dword at 4 misaligned", {63'd0, misalign}, 64'd1);
    acc(1'b1, 1'b0, 10'h106, 2'd1, 1'b0, 64'd0);
    check(misalign === 1'b0 && rdValid === 1'b1, "R4 half at 6 aligned", {63'd0, misalign}, 64'd0);
    acc(1'b0, 1'b1, 10'h131, 2'd0, 1'b1, 64'hA5);
    check(misalign === 1'b0, "R1 odd byte aligned", {63'd0, misalign}, 64'd0);
    readChk(10'h131, 2'd0, 1'b0, 64'hA5, "R1 odd byte stored");
  endtask

  task automatic tBoth();
    readChk(10'h100, 2'd0, 1'b0, 64'h54, "R6 prior value");
    acc(1'b1, 1'b1, 10'h140, 2'd2, 1'b0, 64'hCAFEF00D);
    check(rdValid === 1'b0 && rdData === 64'h54, "R8 no read result", rdData, 64'h54);
    @(negedge clk);
    check(rdValid === 1'b0 && rdData === 64'h54, "R6 hold when idle", rdData, 64'h54);
    readChk(10'h140, 2'd2, 1'b0, 64'hCAFEF00D, "R8 write landed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    // byte 0x104 was never written; clear it so the neighbour check is defined
    acc(1'b0, 1'b1, 10'h104, 2'd0, 1'b0, 64'h00);
    tLittle();
    tBig();
    tCross();
    tZeroFill();
    tMisalign();
    tBoth();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule